// File: doc/BRIEF.md
# Scan-In State Justification Sequencer

This block loads a chosen 3-bit value into a scrambled three-stage scan segment. In that segment the flip-flops are linked through inverters and XOR feed-forward paths instead of a plain chain. Shifting the target bits in reverse order therefore does not give the target. The sequencer turns the requested state into the one serial input sequence that does. It sends that sequence on three consecutive clocks with the scan enable asserted. The earlier content of the segment plays no part.

A request is one clock of `start` with the wanted state on `tgt_state`. Bit 1 holds stage y1, bit 2 holds y2 and bit 3 holds y3. The target is captured when the request is accepted. `busy` stays high until the end-of-sequence pulse, and requests made in that window are dropped.

Top module: `scan_justify_seq`

## Requirements
- R1: The first bit driven on `scan_in` while `scan_enable` is high equals 1 XOR y1 XOR y3 of the accepted target.
- R2: The second bit driven on `scan_in` equals the inverse of y2 of the accepted target.
- R3: The third bit driven on `scan_in` equals y1 of the accepted target.
- R4: `scan_enable` is high for exactly three consecutive cycles, starting the cycle after an accepted `start`. Those three bits move the segment (next y1 = x, next y2 = NOT y1, next y3 = x XOR y2) into the target from any prior state.
- R5: `done` is high for exactly one cycle, the cycle right after the last shift cycle, and `scan_enable` is low during it.
- R6: The target is captured on the accepted `start`. Changes on `tgt_state` after that do not alter the emitted bits.
- R7: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` seen while `busy` is high is ignored.
- R8: While reset is held, and directly after it, `scan_enable`, `busy` and `done` are low. This applies even when reset comes in the middle of a sequence.
- R9: `scan_in` is low whenever `scan_enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted when idle |
| tgt_state | input | 3 | Wanted segment state, bit 1 = y1 .. bit 3 = y3 |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-sequence pulse |
| scan_in | output | 1 | Serial data to the segment |
| scan_enable | output | 1 | Shift enable to the segment |

## Verification
The bound checker checks the following on every cycle:
- the first, second and third emitted bits against the target captured one, two and three cycles earlier;
- the three-cycle limit on `scan_enable`;
- the single-cycle `done` that follows the fall of `scan_enable`;
- `scan_in` staying quiet outside shifting.

Only the bench scenarios can show the following:
- that the bits really place a modelled segment into the target from arbitrary starting contents;
- that a request made mid-sequence, or a target changed after capture, has no effect at the pins;
- that a reset in the middle of a sequence returns the block to idle.

// File: rtl/sjs_pkg.sv
package sjs_pkg;
   localparam int unsigned SEG_STAGES = 3;

   typedef enum logic [1:0] {
      SJS_IDLE  = 2'd0,
      SJS_SHIFT = 2'd1,
      SJS_DONE  = 2'd2
   } sjs_state_e;

   // Serial sequence for the scrambled segment, index 0 sent first.
   function automatic logic [SEG_STAGES-1:0] justify_seq(input logic [SEG_STAGES:1] tgt);
      logic [SEG_STAGES-1:0] s;
      s[0] = 1'b1 ^ tgt[1] ^ tgt[3];
      s[1] = ~tgt[2];
      s[2] = tgt[1];
      return s;
   endfunction
endpackage

// File: rtl/sjs_encoder.sv
module sjs_encoder #(
   parameter int unsigned STAGES = 3
) (
   input  logic [STAGES:1]   tgt,
   output logic [STAGES-1:0] seq
);
   import sjs_pkg::*;

   if (STAGES != SEG_STAGES) begin : g_bad_stages
      initial $error("sjs_encoder: STAGES must equal %0d", SEG_STAGES);
   end

   always_comb seq = justify_seq(tgt);
endmodule

// File: rtl/sjs_fsm.sv
module sjs_fsm #(
   parameter int unsigned STAGES = 3,
   localparam int unsigned CW = $clog2(STAGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [STAGES-1:0] seq_in,
   output logic              busy,
   output logic              done,
   output logic              scan_in,
   output logic              scan_enable
);
   import sjs_pkg::*;

   localparam logic [CW-1:0] LAST = CW'(STAGES - 1);

   sjs_state_e        state_q;
   logic [CW-1:0]     idx_q;
   logic [STAGES-1:0] seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SJS_IDLE;
         idx_q   <= '0;
         seq_q   <= '0;
      end else begin
         unique case (state_q)
            SJS_IDLE: begin
               if (start) begin
                  seq_q   <= seq_in;
                  idx_q   <= '0;
                  state_q <= SJS_SHIFT;
               end
            end
            SJS_SHIFT: begin
               if (idx_q == LAST) state_q <= SJS_DONE;
               else               idx_q   <= idx_q + 1'b1;
            end
            SJS_DONE: state_q <= SJS_IDLE;
            default:  state_q <= SJS_IDLE;
         endcase
      end
   end

   always_comb begin
      scan_enable = (state_q == SJS_SHIFT);
      done        = (state_q == SJS_DONE);
      busy        = (state_q != SJS_IDLE);
      scan_in     = scan_enable ? seq_q[idx_q] : 1'b0;
   end
endmodule

// File: rtl/scan_justify_seq.sv
module scan_justify_seq #(
   parameter int unsigned STAGES = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [STAGES:1] tgt_state,
   output logic            busy,
   output logic            done,
   output logic            scan_in,
   output logic            scan_enable
);
   logic [STAGES-1:0] seq;

   sjs_encoder #(.STAGES(STAGES)) i_enc (
      .tgt (tgt_state),
      .seq (seq)
   );

   sjs_fsm #(.STAGES(STAGES)) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .seq_in      (seq),
      .busy        (busy),
      .done        (done),
      .scan_in     (scan_in),
      .scan_enable (scan_enable)
   );
endmodule

// File: rtl/scan_justify_seq_chk.sv
module scan_justify_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [3:1] tgt_state,
   input logic       busy,
   input logic       done,
   input logic       scan_in,
   input logic       scan_enable
);
   logic [2:0] se_run;
   logic [3:1] tgt_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         se_run  <= '0;
         tgt_cap <= '0;
      end else begin
         se_run <= scan_enable ? se_run + 1'b1 : 3'd0;
         if (start && !busy) tgt_cap <= tgt_state;
      end
   end

   AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (scan_enable && scan_in == (1'b1 ^ tgt_cap[1] ^ tgt_cap[3]))); // R1
   AST_SECOND_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_enable && se_run == 3'd1) |-> (scan_in == ~tgt_cap[2])); // R2
   AST_THIRD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_enable && se_run == 3'd2) |-> (scan_in == tgt_cap[1])); // R3
   AST_SE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      scan_enable |-> (se_run < 3'd3)); // R4
   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_enable) |-> (done && se_run == 3'd3)); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_BUSY_COVER: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_enable || done) |-> busy); // R7
   AST_QUIET_IN: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_enable |-> !scan_in); // R9
endmodule

bind scan_justify_seq scan_justify_seq_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .tgt_state   (tgt_state),
   .busy        (busy),
   .done        (done),
   .scan_in     (scan_in),
   .scan_enable (scan_enable)
);

// File: tb/test_scan_justify_seq.sv
`timescale 1ns/1ps
module test_scan_justify_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:1] tgt_state = '0;
   logic       busy, done, scan_in, scan_enable;
   int         n_chk = 0;
   int         n_bad = 0;
   logic [3:1] seg;  // bench model of the scrambled segment

   always #4 clk = ~clk;

   scan_justify_seq i_scan_justify_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .tgt_state (tgt_state),
      .busy (busy), .done (done), .scan_in (scan_in), .scan_enable (scan_enable)
   );

   always @(posedge clk) if (scan_enable)
      seg <= {scan_in ^ seg[2], ~seg[1], scan_in};

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic launch(input logic [3:1] t);
      @(negedge clk); tgt_state = t; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // after launch we sit in the first shift cycle (negedge)
   task automatic expect_seq(input logic [3:1] t, input string tag);
      check({"R1 ", tag}, {6'd0, scan_enable, scan_in}, {6'd0, 1'b1, 1'b1 ^ t[1] ^ t[3]});
      check({"R7 ", tag}, {7'd0, busy}, 8'd1);
      @(negedge clk);
      check({"R2 ", tag}, {6'd0, scan_enable, scan_in}, {6'd0, 1'b1, ~t[2]});
      @(negedge clk);
      check({"R3 ", tag}, {6'd0, scan_enable, scan_in}, {6'd0, 1'b1, t[1]});
      @(negedge clk);
      check({"R5 ", tag}, {5'd0, done, scan_enable, busy}, 8'b101);
      check({"R9 ", tag}, {7'd0, scan_in}, 8'd0);
      check({"R4 ", tag}, {5'd0, seg}, {5'd0, t});
      @(negedge clk);
      check({"R5 idle ", tag}, {5'd0, done, scan_enable, busy}, 8'd0);
   endtask

   task automatic t_reset;
      check("R8 reset", {4'd0, busy, done, scan_enable, scan_in}, 8'd0);
   endtask

   task automatic t_all_targets;
      for (int i = 0; i < 8; i++) begin
         seg = 3'(7 - i);
         launch(3'(i));
         expect_seq(3'(i), "sweep");
      end
   endtask

   task automatic t_ignore_start;
      seg = 3'b010;
      launch(3'b011);
      tgt_state = 3'b100; start = 1'b1;  // request while busy, target changed
      @(negedge clk); start = 1'b0;
      check("R2 R6 R7 ignored", {6'd0, scan_enable, scan_in}, {6'd0, 1'b1, 1'b0});
      @(negedge clk);
      check("R3 R6 R7 ignored", {6'd0, scan_enable, scan_in}, 8'b11);
      tgt_state = 3'b000; start = 1'b1;  // request during done cycle
      @(negedge clk);
      check("R5 R7 ignored", {6'd0, done, busy}, 8'b11);
      check("R4 R6 final", {5'd0, seg}, 8'b011);
      @(negedge clk); start = 1'b0;
      check("R7 dropped", {6'd0, busy, scan_enable}, 8'd0);
   endtask

   task automatic t_mid_reset;
      launch(3'b101);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R8 mid reset", {4'd0, busy, done, scan_enable, scan_in}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset", {4'd0, busy, done, scan_enable, scan_in}, 8'd0);
      seg = 3'b111;
      launch(3'b110);
      expect_seq(3'b110, "post reset");
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_all_targets();
            t_ignore_start();
            t_mid_reset();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=expired expected=finished");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule